// File: doc/BRIEF.md
# Touch Digitizer Frame Controller

This block is the host-side master for a resistive touch digitizer on a four-wire serial bus. It has a chip select, a serial clock, a data line to the slave and a data line back. A low level on the pen interrupt line, or a one-cycle software request, starts a burst of conversion frames. Each frame carries an eight-bit command word toward the slave and brings a twelve-bit result back. A pen burst reads the X coordinate and then the Y coordinate, and reports both together. A software burst reads one auxiliary channel whose address comes from the request.

The serial clock comes from the system clock through a programmable half-period divider. Three frame layouts are offered. In the long layout every frame takes 24 clocks, sent as three byte bursts. In the two overlapped layouts the next command word starts while the current result is still arriving, so a new frame begins every 16 or every 15 clocks. The controller keeps the X command's touch drivers powered and lets the final Y command power down. This lets the panel settle between the two reads.

Top module: `tsc_host_ctrl`

## Requirements
- R1: Each command word is sent MSB first as {1, addr[2:0], 0, se, pd[1:0]}, where a leading 1 is the start bit, the 0 selects 12-bit conversion, se is the reference select and pd the power bits. mosi_o is 1 when cs_no falls, changes only while sclk_o falls, and holds its value across every rising edge.
- R2: A pen burst sends two commands: X with addr 101, se 0, pd 11 (byte D3h), then Y with addr 001, se 0, pd 00 (byte 90h).
- R3: A software burst sends one command with addr equal to the latched sw_chan_i, se 1 and pd 00. Channel 010 gives A4h and channel 110 gives E4h.
- R4: The result of a frame is taken from miso_i on the 10th to 21st rising edges after the frame's first command edge, counting that edge as the 1st. The bits arrive MSB first and form a 12-bit value.
- R5: frame_mode_i is latched when a burst starts. Value 0 gives a frame period of 24 rising edges, 1 gives 16 and 2 gives 15, with the next command starting that many edges after the previous one. Value 3 behaves as 0. A burst of N commands has (N-1)*period+24 rising edges while cs_no is low.
- R6: In the 24-edge layout, sclk_o stays low for two half-periods after every 8th falling edge except the last one. Every other low phase lasts one half-period.
- R7: A half-period is clk_div_i+1 system clocks. Each high phase of sclk_o lasts exactly one half-period. cs_no is low for at least one half-period before the first rising edge. sclk_o is low whenever cs_no is high.
- R8: The pen input is synchronised by two flops. Its low level starts a pen burst while the controller is idle. When cs_no rises at the end of the burst, xy_valid_o pulses for one cycle, with x_o and y_o holding the X and Y results.
- R9: Changes on pen_irq_ni while a burst is running start no further burst.
- R10: A software request is held pending until the controller is idle, and the latest channel wins. A pen burst goes before a pending request. At the end of a software burst, aux_valid_o pulses for one cycle with aux_o holding the result.
- R11: During reset, cs_no is 1, sclk_o is 0, mosi_o is 0, and xy_valid_o and aux_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_div_i | input | DIV_W | Half-period of the serial clock, minus one, in system clocks |
| frame_mode_i | input | 2 | Frame layout: 0 long, 1 overlapped 16, 2 overlapped 15 |
| pen_irq_ni | input | 1 | Pen-down interrupt from the digitizer, active low, asynchronous |
| sw_req_i | input | 1 | One-cycle request to read an auxiliary channel |
| sw_chan_i | input | 3 | Channel address for the software request |
| miso_i | input | 1 | Serial data from the digitizer |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial command data to the digitizer |
| xy_valid_o | output | 1 | One-cycle strobe: a coordinate pair is ready |
| x_o | output | RES_W | X coordinate result |
| y_o | output | RES_W | Y coordinate result |
| aux_valid_o | output | 1 | One-cycle strobe: an auxiliary result is ready |
| aux_o | output | RES_W | Auxiliary channel result |

## Verification
The bench builds the block with RES_W at 12 and DIV_W at 8. It drives clk_div_i to 0, 1, 2 and 3, so half-periods of one to four system clocks are covered. A half-period of one clock is the tightest case for sampling miso_i right after the slave changes it. All four frame_mode_i codes are run, so the overlap of the Y command with the arriving X bits is seen at both the 16-edge and the 15-edge spacing, as well as the byte gaps of the long layout. Pen pulses during a burst, and software requests that arrive while a burst is running, bring the pending-request path and the pen-over-software priority into view.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned CMD_W = 8;

  typedef enum logic [1:0] {
    FM_LONG  = 2'd0,
    FM_OVL16 = 2'd1,
    FM_OVL15 = 2'd2,
    FM_RSVD  = 2'd3
  } frame_mode_e;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_LEAD,
    SEQ_RUN,
    SEQ_TAIL,
    SEQ_GUARD
  } seq_state_e;

  localparam logic [2:0] ADDR_X   = 3'b101;
  localparam logic [2:0] ADDR_Y   = 3'b001;
  localparam logic [1:0] PD_HOLD  = 2'b11;
  localparam logic [1:0] PD_SLEEP = 2'b00;

  function automatic logic [CMD_W-1:0] build_cmd(input logic [2:0] addr,
                                                 input logic       single_ended,
                                                 input logic [1:0] pd);
    return {1'b1, addr, 1'b0, single_ended, pd};
  endfunction
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/tsc_sclk_tick.sv
module tsc_sclk_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tsc_req_arb.sv
module tsc_req_arb (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ready_i,
  input  logic       pen_low_i,
  input  logic       sw_req_i,
  input  logic [2:0] sw_chan_i,
  output logic       start_o,
  output logic       pen_o,
  output logic [2:0] chan_o
);
  logic       pend_q;
  logic [2:0] chan_q;

  assign start_o = ready_i && (pen_low_i || pend_q);
  assign pen_o   = pen_low_i;
  assign chan_o  = chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      chan_q <= '0;
    end else begin
      if (sw_req_i) begin
        pend_q <= 1'b1;
        chan_q <= sw_chan_i;
      end else if (start_o && !pen_low_i) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tsc_frame_seq.sv
module tsc_frame_seq
  import tsc_pkg::*;
#(
  parameter int unsigned RES_W   = 12,
  parameter int unsigned TRAIL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pen_i,
  input  logic [2:0]       chan_i,
  input  logic [1:0]       fmode_i,
  input  logic             tick_i,
  input  logic             miso_i,
  output logic             run_o,
  output logic             ready_o,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             mosi_o,
  output logic             xy_valid_o,
  output logic [RES_W-1:0] x_o,
  output logic [RES_W-1:0] y_o,
  output logic             aux_valid_o,
  output logic [RES_W-1:0] aux_o
);
  localparam int unsigned BURST_MAX  = 2;
  localparam int unsigned BI_W       = $clog2(BURST_MAX);
  localparam int unsigned DATA_OFS   = CMD_W + 1;
  localparam int unsigned LONG_FRAME = CMD_W + 1 + RES_W + TRAIL_W;
  localparam int unsigned PER_16     = 2 * CMD_W;
  localparam int unsigned PER_15     = RES_W + TRAIL_W;
  localparam int unsigned EDGE_W     = $clog2(BURST_MAX * LONG_FRAME + 1);
  localparam int unsigned IDX_W      = $clog2(RES_W);
  localparam int unsigned CB_W       = $clog2(CMD_W);

  seq_state_e             state_q;
  logic                   sclk_q, cs_n_q, mosi_q, gap_q, pen_q, long_q;
  logic [EDGE_W-1:0]      edge_q, period_q, total_q, per_sel;
  logic [CMD_W-1:0]       cmd_q [BURST_MAX];
  logic [RES_W-1:0]       res_q [BURST_MAX];
  logic [RES_W-1:0]       x_q, y_q, aux_q;
  logic                   xy_v_q, aux_v_q;

  logic                   next_mosi;
  logic [BURST_MAX-1:0]   cap_hit;
  logic [IDX_W-1:0]       cap_idx [BURST_MAX];
  int                     burst_len;

  always_comb begin
    case (frame_mode_e'(fmode_i))
      FM_OVL16: per_sel = EDGE_W'(PER_16);
      FM_OVL15: per_sel = EDGE_W'(PER_15);
      default:  per_sel = EDGE_W'(LONG_FRAME);
    endcase
  end

  assign burst_len = pen_q ? 2 : 1;

  // map the running edge index onto each frame of the burst
  always_comb begin
    int rel;
    next_mosi = 1'b0;
    cap_hit   = '0;
    for (int k = 0; k < BURST_MAX; k++) begin
      cap_idx[BI_W'(k)] = '0;
      rel = int'(edge_q) - k * int'(period_q);
      if (k < burst_len && rel >= 0 && rel < int'(CMD_W))
        next_mosi = cmd_q[BI_W'(k)][CB_W'(int'(CMD_W) - 1 - rel)];
      if (k < burst_len && rel >= int'(DATA_OFS) && rel < int'(DATA_OFS + RES_W)) begin
        cap_hit[BI_W'(k)] = 1'b1;
        cap_idx[BI_W'(k)] = IDX_W'(int'(DATA_OFS + RES_W) - 1 - rel);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      sclk_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      mosi_q   <= 1'b0;
      gap_q    <= 1'b0;
      pen_q    <= 1'b0;
      long_q   <= 1'b1;
      edge_q   <= '0;
      period_q <= EDGE_W'(LONG_FRAME);
      total_q  <= '0;
      cmd_q    <= '{default: '0};
      res_q    <= '{default: '0};
      x_q      <= '0;
      y_q      <= '0;
      aux_q    <= '0;
      xy_v_q   <= 1'b0;
      aux_v_q  <= 1'b0;
    end else begin
      xy_v_q  <= 1'b0;
      aux_v_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: if (start_i) begin
          pen_q    <= pen_i;
          long_q   <= (per_sel == EDGE_W'(LONG_FRAME));
          period_q <= per_sel;
          total_q  <= pen_i ? per_sel + EDGE_W'(LONG_FRAME) : EDGE_W'(LONG_FRAME);
          cmd_q[0] <= pen_i ? build_cmd(ADDR_X, 1'b0, PD_HOLD)
                            : build_cmd(chan_i, 1'b1, PD_SLEEP);
          cmd_q[1] <= build_cmd(ADDR_Y, 1'b0, PD_SLEEP);
          res_q    <= '{default: '0};
          cs_n_q   <= 1'b0;
          mosi_q   <= 1'b1;
          edge_q   <= '0;
          gap_q    <= 1'b0;
          state_q  <= SEQ_LEAD;
        end
        SEQ_LEAD: if (tick_i) state_q <= SEQ_RUN;
        SEQ_RUN: if (tick_i) begin
          if (!sclk_q) begin
            if (gap_q) begin
              gap_q <= 1'b0;
            end else begin
              sclk_q <= 1'b1;
              edge_q <= edge_q + 1'b1;
              for (int k = 0; k < BURST_MAX; k++)
                if (cap_hit[BI_W'(k)]) res_q[BI_W'(k)][cap_idx[BI_W'(k)]] <= miso_i;
            end
          end else begin
            sclk_q <= 1'b0;
            if (edge_q == total_q) begin
              mosi_q  <= 1'b0;
              state_q <= SEQ_TAIL;
            end else begin
              mosi_q <= next_mosi;
              // byte boundary pause in the long layout
              if (long_q && edge_q[CB_W-1:0] == '0) gap_q <= 1'b1;
            end
          end
        end
        SEQ_TAIL: if (tick_i) begin
          cs_n_q  <= 1'b1;
          state_q <= SEQ_GUARD;
          if (pen_q) begin
            x_q    <= res_q[0];
            y_q    <= res_q[1];
            xy_v_q <= 1'b1;
          end else begin
            aux_q   <= res_q[0];
            aux_v_q <= 1'b1;
          end
        end
        SEQ_GUARD: if (tick_i) state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == SEQ_IDLE);
  assign run_o       = (state_q != SEQ_IDLE);
  assign sclk_o      = sclk_q;
  assign cs_no       = cs_n_q;
  assign mosi_o      = mosi_q;
  assign xy_valid_o  = xy_v_q;
  assign aux_valid_o = aux_v_q;
  assign x_o         = x_q;
  assign y_o         = y_q;
  assign aux_o       = aux_q;
endmodule

// File: rtl/tsc_host_ctrl.sv
module tsc_host_ctrl #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] clk_div_i,
  input  logic [1:0]       frame_mode_i,
  input  logic             pen_irq_ni,
  input  logic             sw_req_i,
  input  logic [2:0]       sw_chan_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             mosi_o,
  output logic             xy_valid_o,
  output logic [RES_W-1:0] x_o,
  output logic [RES_W-1:0] y_o,
  output logic             aux_valid_o,
  output logic [RES_W-1:0] aux_o
);
  logic pen_n_sync, ready, run, tick, start, start_pen;
  logic [2:0] start_chan;

  tsc_sync #(.STAGES(2), .RST_VAL(1'b1)) u_pen_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pen_irq_ni), .q_o(pen_n_sync)
  );

  tsc_req_arb u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(ready), .pen_low_i(!pen_n_sync),
    .sw_req_i(sw_req_i), .sw_chan_i(sw_chan_i),
    .start_o(start), .pen_o(start_pen), .chan_o(start_chan)
  );

  tsc_sclk_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .div_i(clk_div_i), .tick_o(tick)
  );

  tsc_frame_seq #(.RES_W(RES_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .pen_i(start_pen),
    .chan_i(start_chan), .fmode_i(frame_mode_i), .tick_i(tick), .miso_i(miso_i),
    .run_o(run), .ready_o(ready), .sclk_o(sclk_o), .cs_no(cs_no), .mosi_o(mosi_o),
    .xy_valid_o(xy_valid_o), .x_o(x_o), .y_o(y_o),
    .aux_valid_o(aux_valid_o), .aux_o(aux_o)
  );
endmodule

// File: rtl/tsc_host_ctrl_chk.sv
module tsc_host_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic cs_no,
  input logic mosi_o,
  input logic xy_valid_o,
  input logic aux_valid_o
);
  // R7
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  // R1
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_o));

  // R1
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> mosi_o);

  // R7
  lead_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |=> !sclk_o);

  // R8
  xy_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xy_valid_o |-> ($rose(cs_no) && !aux_valid_o));

  // R10
  aux_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_valid_o |-> $rose(cs_no));

  // R8
  xy_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xy_valid_o |=> !xy_valid_o);
endmodule

bind tsc_host_ctrl tsc_host_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_o(sclk_o), .cs_no(cs_no),
  .mosi_o(mosi_o), .xy_valid_o(xy_valid_o), .aux_valid_o(aux_valid_o)
);

// File: tb/tsc_host_ctrl_tb.sv
module tsc_host_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;
  localparam int RES_W = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [DIV_W-1:0] clk_div_i = 8'd1;
  logic [1:0] frame_mode_i = 2'd0;
  logic pen_irq_ni = 1'b1;
  logic sw_req_i = 1'b0;
  logic [2:0] sw_chan_i = 3'd0;
  logic miso_i = 1'b0;
  logic sclk_o, cs_no, mosi_o, xy_valid_o, aux_valid_o;
  logic [RES_W-1:0] x_o, y_o, aux_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsc_host_ctrl #(.DIV_W(DIV_W), .RES_W(RES_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .clk_div_i(clk_div_i), .frame_mode_i(frame_mode_i),
    .pen_irq_ni(pen_irq_ni), .sw_req_i(sw_req_i), .sw_chan_i(sw_chan_i), .miso_i(miso_i),
    .sclk_o(sclk_o), .cs_no(cs_no), .mosi_o(mosi_o), .xy_valid_o(xy_valid_o),
    .x_o(x_o), .y_o(y_o), .aux_valid_o(aux_valid_o), .aux_o(aux_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd_byte(input logic [2:0] a, input logic se,
                                          input logic [1:0] pd);
    return {1'b1, a, 1'b0, se, pd};
  endfunction

  function automatic int period_of(input logic [1:0] m);
    return (m == 2'd1) ? 16 : (m == 2'd2) ? 15 : 24;
  endfunction

  // reference slave and protocol model
  logic [7:0]  exp_cmd_q [$];
  logic [23:0] exp_xy_q [$];
  logic [11:0] exp_aux_q [$];
  bit          sched [int];
  logic [31:0] lcg = 32'h1234_5678;
  int bursts = 0;
  int n_xy = 0;
  int n_aux = 0;
  logic prev_sclk = 1'b0;
  logic prev_cs = 1'b1;
  int rise_cnt, lead_cnt, high_cnt, low_cnt, nframes, bits_in, fstart, prev_fstart;
  bit cmd_act;
  logic [7:0] sr;
  logic [11:0] pend_x;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (cs_no) check(!sclk_o, "R7 sclk idle", sclk_o, 0);
      if (prev_cs && !cs_no) begin
        check(mosi_o, "R1 start bit at cs fall", mosi_o, 1);
        rise_cnt = 0; lead_cnt = 1; nframes = 0; cmd_act = 0; bits_in = 0;
        sched.delete(); miso_i = 1'b0;
      end else if (!cs_no) begin
        if (sclk_o && !prev_sclk) begin
          if (rise_cnt == 0)
            check(lead_cnt >= int'(clk_div_i) + 1, "R7 cs lead", lead_cnt, clk_div_i + 1);
          else if (period_of(frame_mode_i) == 24 && rise_cnt % 8 == 0)
            check(low_cnt == 2 * (int'(clk_div_i) + 1), "R6 byte gap", low_cnt,
                  2 * (clk_div_i + 1));
          else
            check(low_cnt == int'(clk_div_i) + 1, "R7 low phase", low_cnt, clk_div_i + 1);
          rise_cnt++;
          high_cnt = 1;
          if (!cmd_act && mosi_o) begin
            cmd_act = 1; bits_in = 1; sr = 8'h01; fstart = rise_cnt;
          end else if (cmd_act) begin
            sr = {sr[6:0], mosi_o};
            bits_in++;
            if (bits_in == 8) begin
              logic [11:0] val;
              cmd_act = 0;
              nframes++;
              if (nframes > 1)
                check(fstart - prev_fstart == period_of(frame_mode_i), "R5 frame period",
                      fstart - prev_fstart, period_of(frame_mode_i));
              prev_fstart = fstart;
              if (exp_cmd_q.size() == 0) check(0, "R1 unexpected command", sr, 0);
              else begin
                logic [7:0] e;
                e = exp_cmd_q.pop_front();
                check(sr == e, (sr[6:4] == 3'b101 || sr[6:4] == 3'b001) ?
                      "R2 coordinate command" : "R3 aux command", sr, e);
              end
              lcg = lcg * 32'd1103515245 + 32'd12345;
              val = lcg[27:16];
              for (int i = 0; i < 12; i++) sched[fstart + 9 + i] = val[11-i];
              if (sr[6:4] == 3'b101 && !sr[2]) pend_x = val;
              else if (sr[6:4] == 3'b001 && !sr[2]) exp_xy_q.push_back({pend_x, val});
              else exp_aux_q.push_back(val);
            end
          end
        end else if (!sclk_o && prev_sclk) begin
          check(high_cnt == int'(clk_div_i) + 1, "R7 high phase", high_cnt, clk_div_i + 1);
          low_cnt = 1;
          miso_i = sched.exists(rise_cnt + 1) ? sched[rise_cnt + 1] : 1'b0;
        end else if (sclk_o) high_cnt++;
        else if (rise_cnt == 0) lead_cnt++;
        else low_cnt++;
      end else if (!prev_cs && cs_no) begin
        check(nframes > 0 && rise_cnt == (nframes - 1) * period_of(frame_mode_i) + 24,
              "R5 burst edge count", rise_cnt, (nframes - 1) * period_of(frame_mode_i) + 24);
        bursts++;
      end
      if (xy_valid_o) begin
        n_xy++;
        if (exp_xy_q.size() == 0) check(0, "R8 unexpected xy strobe", {x_o, y_o}, 0);
        else begin
          logic [23:0] e;
          e = exp_xy_q.pop_front();
          check({x_o, y_o} == e, "R4 R8 coordinate pair", {x_o, y_o}, e);
        end
      end
      if (aux_valid_o) begin
        n_aux++;
        if (exp_aux_q.size() == 0) check(0, "R10 unexpected aux strobe", aux_o, 0);
        else begin
          logic [11:0] e;
          e = exp_aux_q.pop_front();
          check(aux_o == e, "R4 R10 aux result", aux_o, e);
        end
      end
    end
    prev_sclk = sclk_o;
    prev_cs = cs_no;
  end

  task automatic wait_bursts(input int n);
    int t = 0;
    while (bursts < n && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(bursts >= n, "R8 burst completion", bursts, n);
    repeat (4 * (int'(clk_div_i) + 2) + 6) @(negedge clk);
  endtask

  task automatic pen_pulse(input int len);
    pen_irq_ni = 1'b0;
    repeat (len) @(negedge clk);
    pen_irq_ni = 1'b1;
  endtask

  task automatic sw_pulse(input logic [2:0] ch);
    sw_chan_i = ch;
    sw_req_i = 1'b1;
    @(negedge clk);
    sw_req_i = 1'b0;
  endtask

  task automatic push_pen;
    exp_cmd_q.push_back(cmd_byte(3'b101, 1'b0, 2'b11));
    exp_cmd_q.push_back(cmd_byte(3'b001, 1'b0, 2'b00));
  endtask

  task automatic wait_cs_low;
    int t = 0;
    while (cs_no && t < 1000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    int b;
    repeat (3) @(negedge clk);
    // R11
    check(cs_no === 1'b1, "R11 reset cs", cs_no, 1);
    check(sclk_o === 1'b0, "R11 reset sclk", sclk_o, 0);
    check(mosi_o === 1'b0, "R11 reset mosi", mosi_o, 0);
    check(xy_valid_o === 1'b0 && aux_valid_o === 1'b0, "R11 reset strobes",
          {xy_valid_o, aux_valid_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // long layout, pen read
    clk_div_i = 8'd1; frame_mode_i = 2'd0; b = bursts;
    push_pen(); pen_pulse(5); wait_bursts(b + 1);
    check(n_xy == 1, "R8 one pair after pen", n_xy, 1);

    // 16-edge overlap, fastest clock
    clk_div_i = 8'd0; frame_mode_i = 2'd1; b = bursts;
    push_pen(); pen_pulse(5); wait_bursts(b + 1);
    check(n_xy == 2, "R5 pair in 16-edge layout", n_xy, 2);

    // 15-edge overlap, pen toggled mid-burst
    clk_div_i = 8'd2; frame_mode_i = 2'd2; b = bursts;
    push_pen(); pen_pulse(5); wait_cs_low();
    repeat (30) @(negedge clk);
    pen_pulse(6);
    wait_bursts(b + 1);
    repeat (100) @(negedge clk);
    check(bursts == b + 1, "R9 pen ignored while busy", bursts, b + 1);
    check(n_xy == 3, "R9 pair count", n_xy, 3);

    // aux reads
    clk_div_i = 8'd1; frame_mode_i = 2'd0; b = bursts;
    exp_cmd_q.push_back(cmd_byte(3'b010, 1'b1, 2'b00));
    sw_pulse(3'b010); wait_bursts(b + 1);
    check(n_aux == 1, "R3 aux strobe", n_aux, 1);
    frame_mode_i = 2'd2; b = bursts;
    exp_cmd_q.push_back(cmd_byte(3'b110, 1'b1, 2'b00));
    sw_pulse(3'b110); wait_bursts(b + 1);
    check(n_aux == 2, "R3 aux strobe 15-edge", n_aux, 2);

    // request arriving during a pen burst is held
    frame_mode_i = 2'd1; b = bursts;
    push_pen();
    exp_cmd_q.push_back(cmd_byte(3'b110, 1'b1, 2'b00));
    pen_pulse(5); wait_cs_low();
    repeat (10) @(negedge clk);
    sw_pulse(3'b011);
    sw_pulse(3'b110);
    wait_bursts(b + 2);
    check(n_aux == 3 && n_xy == 4, "R10 pending request served", n_aux, 3);

    // pen wins over a pending request
    clk_div_i = 8'd3; frame_mode_i = 2'd3; b = bursts;
    exp_cmd_q.push_back(cmd_byte(3'b010, 1'b1, 2'b00));
    push_pen();
    exp_cmd_q.push_back(cmd_byte(3'b110, 1'b1, 2'b00));
    sw_pulse(3'b010); wait_cs_low();
    repeat (10) @(negedge clk);
    sw_pulse(3'b110);
    pen_irq_ni = 1'b0;
    while (bursts < b + 1) @(negedge clk);
    repeat (3) @(negedge clk);
    wait_cs_low();
    repeat (5) @(negedge clk);
    pen_irq_ni = 1'b1;
    wait_bursts(b + 3);
    check(n_xy == 5 && n_aux == 5, "R10 pen priority", {n_xy[15:0], n_aux[15:0]}, 32'h0005_0005);

    check(exp_cmd_q.size() == 0, "R5 all commands seen", exp_cmd_q.size(), 0);
    check(exp_xy_q.size() == 0 && exp_aux_q.size() == 0, "R8 all results seen",
          exp_xy_q.size() + exp_aux_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(negedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule